// File: doc/BRIEF.md
# Split-Bus Midpoint Balancing Controller

This block keeps the two capacitor halves of a split DC bus at the same voltage. It runs one control update each time a sample strobe arrives. The strobe comes once per switching period and is aligned to the PWM carrier. The block takes the upper and lower capacitor voltages, forms their difference, and negates it to get the control error against a zero set-point. In phase-injection mode it smooths that error with a first-order bilinear low-pass section. It then passes the result through an incremental Tustin PI law, which gives a compensating current.

The block has two modes, and each has its own coefficient pair. In phase-injection mode the block adds one third of the compensating current to each of three incoming phase current references. This makes the converter push a zero-sequence current that returns through the neutral. In chopper mode the filter is bypassed, the phase references pass through unchanged, and the full compensating current drives the reference of an auxiliary half-bridge chopper.

All data are signed 16-bit per-unit values with 12 fraction bits (Q4.12). The voltages are normalised to the bus voltage reference and the currents to the current reference. Coefficients are integers with 16 fraction bits. Every product is rounded half-up before use.

Top module: `midpoint_balancer`

## Requirements
- R1: The control error is the lower voltage minus the upper voltage, which is the zero set-point minus the unbalance (upper − lower), saturated to 16 bits. A higher upper voltage therefore drives the compensating current negative.
- R2: State and outputs change only at a clock edge where `strobe` is high. `valid` is high for exactly the one cycle after each such edge and low otherwise. Between strobes every output holds its value.
- R3: When `mode` = 0 (phase injection), the filtered error is y = sat(round((FLT_B·y_prev + FLT_A·(x + x_prev)) / 2^16)). Here x is the R1 error, and x_prev and y_prev are the values from the previous strobe.
- R4: The compensating current follows u = u_prev + round((K·e − KA·e_prev) / 2^16), where KA = round(K·a / 2^16). In mode 0, e is the filtered error and K, a are K_ZS, A_ZS.
- R5: When `mode` = 1 (chopper), the filter is bypassed, e is the raw R1 error, and K, a are K_CH, A_CH.
- R6: In mode 0, each phase output is sat(ref + round(u·THIRD / 2^16)), using the reference present at the strobe, with THIRD ≈ 2^16/3. `chop_ref` is 0.
- R7: In mode 1, each phase output equals the reference present at the strobe, and `chop_ref` equals u.
- R8: u is clamped to ±`lim`, using the `lim` value present at the strobe. The clamped value is the value stored as u_prev for the next strobe, so the integrator never winds past the limit.
- R9: A synchronous `rst`, or a clock edge where `mode` differs from its value at the previous edge, clears all filter and PI state and all outputs to 0 and suppresses `valid`. This holds even if `strobe` is high at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Sample strobe, one update per high cycle |
| mode | input | 1 | 0 = phase injection with filter, 1 = chopper |
| v_up | input | 16 | Upper capacitor voltage, Q4.12 per-unit |
| v_lo | input | 16 | Lower capacitor voltage, Q4.12 per-unit |
| ref_a | input | 16 | Phase A current reference |
| ref_b | input | 16 | Phase B current reference |
| ref_c | input | 16 | Phase C current reference |
| lim | input | 15 | Magnitude limit for the compensating current |
| valid | output | 1 | Pulse one cycle after an accepted strobe |
| comp | output | 16 | Compensating current u |
| out_a | output | 16 | Adjusted phase A reference |
| out_b | output | 16 | Adjusted phase B reference |
| out_c | output | 16 | Adjusted phase C reference |
| chop_ref | output | 16 | Chopper current reference |

## Verification
The assertions assume the following about the inputs:
- `rst` is high at time zero.
- `lim` is an unsigned magnitude.
- Any mode switch counts as a clear, even when it coincides with a strobe.

The assertions compare outputs against input values sampled one edge earlier, so they do not depend on holding inputs between strobes. Even so, the stimulus changes inputs only at falling edges, gives each strobe a one-cycle pulse followed by a random gap of one to three cycles, draws voltages within ±2 per-unit, and keeps `lim` positive. Directed cases cover the following:
- the sign of the error;
- driving the output into both clamp rails;
- phase sums at the 16-bit ceiling;
- a strobe that coincides with a mode switch;
- a reset in the middle of operation.

// File: rtl/midpoint_balancer.sv
module midpoint_balancer #(
  parameter int DW    = 16,
  parameter int CF    = 16,
  parameter int PW    = 48,
  parameter int FLT_A = 409,
  parameter int FLT_B = 64717,
  parameter int K_ZS  = 108134,
  parameter int A_ZS  = 65485,
  parameter int K_CH  = 917504,
  parameter int A_CH  = 64618,
  parameter int THIRD = 21845
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 strobe,
  input  logic                 mode,
  input  logic signed [DW-1:0] v_up,
  input  logic signed [DW-1:0] v_lo,
  input  logic signed [DW-1:0] ref_a,
  input  logic signed [DW-1:0] ref_b,
  input  logic signed [DW-1:0] ref_c,
  input  logic        [DW-2:0] lim,
  output logic                 valid,
  output logic signed [DW-1:0] comp,
  output logic signed [DW-1:0] out_a,
  output logic signed [DW-1:0] out_b,
  output logic signed [DW-1:0] out_c,
  output logic signed [DW-1:0] chop_ref
);

  localparam longint HALF  = 64'sd1 <<< (CF - 1);
  localparam longint SMAX  = (64'sd1 <<< (DW - 1)) - 1;
  localparam longint SMIN  = -(64'sd1 <<< (DW - 1));
  localparam longint KA_ZS = (longint'(K_ZS) * longint'(A_ZS) + HALF) >>> CF;
  localparam longint KA_CH = (longint'(K_CH) * longint'(A_CH) + HALF) >>> CF;

  function automatic logic signed [PW-1:0] rnd(input logic signed [PW-1:0] v);
    return (v + PW'(HALF)) >>> CF;
  endfunction

  function automatic logic signed [DW-1:0] sat(input logic signed [PW-1:0] v);
    if (v > PW'(SMAX)) return DW'(SMAX);
    if (v < PW'(SMIN)) return DW'(SMIN);
    return v[DW-1:0];
  endfunction

  logic signed [DW-1:0] xp, yp, ep;
  logic                 mode_q;
  logic                 clr;
  logic signed [DW-1:0] err, filt, e, unew, third;
  logic signed [PW-1:0] kk, ka, sum, limw;

  assign clr  = rst || (mode != mode_q);
  assign err  = sat(PW'(v_lo) - PW'(v_up));
  assign filt = sat(rnd(PW'(FLT_B) * PW'(yp) + PW'(FLT_A) * (PW'(err) + PW'(xp))));
  assign e    = mode ? err : filt;
  assign kk   = mode ? PW'(K_CH) : PW'(K_ZS);
  assign ka   = mode ? PW'(KA_CH) : PW'(KA_ZS);
  assign sum  = PW'(comp) + rnd(kk * PW'(e) - ka * PW'(ep));
  assign limw = PW'(signed'({1'b0, lim}));

  always_comb begin
    if (sum > limw)       unew = DW'(limw);
    else if (sum < -limw) unew = DW'(-limw);
    else                  unew = DW'(sum);
  end

  assign third = sat(rnd(PW'(THIRD) * PW'(unew)));

  always_ff @(posedge clk) begin
    mode_q <= mode;
    if (clr) begin
      valid <= 1'b0;
      xp <= '0; yp <= '0; ep <= '0;
      comp <= '0; out_a <= '0; out_b <= '0; out_c <= '0; chop_ref <= '0;
    end else begin
      valid <= strobe;
      if (strobe) begin
        if (!mode) begin
          xp <= err;
          yp <= filt;
        end
        ep   <= e;
        comp <= unew;
        out_a <= mode ? ref_a : sat(PW'(ref_a) + PW'(third));
        out_b <= mode ? ref_b : sat(PW'(ref_b) + PW'(third));
        out_c <= mode ? ref_c : sat(PW'(ref_c) + PW'(third));
        chop_ref <= mode ? unew : '0;
      end
    end
  end

  assert_valid_follows_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    (strobe && mode == $past(mode)) |=> valid);

  assert_valid_needs_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    valid |-> $past(strobe));

  assert_hold_between_strobes_R2: assert property (@(posedge clk) disable iff (rst)
    (!strobe && mode == $past(mode)) |=> ($stable(comp) && $stable(out_a) && $stable(chop_ref)));

  assert_no_overshoot_R8: assert property (@(posedge clk) disable iff (rst)
    valid |-> (comp <= $signed({1'b0, $past(lim)}) && comp >= -$signed({1'b0, $past(lim)})));

  assert_mode_switch_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (mode != $past(mode)) |=> (comp == '0 && chop_ref == '0 && !valid));

  assert_chopper_passthrough_R7: assert property (@(posedge clk) disable iff (rst)
    (valid && $past(mode)) |-> (out_a == $past(ref_a) && chop_ref == comp));

  assert_injection_chop_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (valid && !$past(mode)) |-> chop_ref == '0);

endmodule

// File: tb/midpoint_balancer_test.sv
module midpoint_balancer_test;
  localparam longint CF = 16, HALF = 32768, SMAX = 32767, SMIN = -32768;
  localparam longint FA = 409, FB = 64717, KZS = 108134, AZS = 65485;
  localparam longint KCH = 917504, ACH = 64618, TH = 21845;

  logic clk = 0, rst = 1, strobe = 0, mode = 0;
  logic signed [15:0] v_up = 0, v_lo = 0, ref_a = 0, ref_b = 0, ref_c = 0;
  logic [14:0] lim = 15'd1000;
  logic valid;
  logic signed [15:0] comp, out_a, out_b, out_c, chop_ref;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  longint mxp = 0, myp = 0, mep = 0, mu = 0, ea = 0, eb = 0, ec = 0, ech = 0;
  bit clamped;

  midpoint_balancer uut (.clk(clk), .rst(rst), .strobe(strobe), .mode(mode), .v_up(v_up), .v_lo(v_lo),
    .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c), .lim(lim), .valid(valid), .comp(comp),
    .out_a(out_a), .out_b(out_b), .out_c(out_c), .chop_ref(chop_ref));

  always #5 clk = ~clk;

  function automatic longint rnd(longint v); return (v + HALF) >>> CF; endfunction
  function automatic longint sat(longint v);
    return v > SMAX ? SMAX : (v < SMIN ? SMIN : v);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic mclear(); mxp = 0; myp = 0; mep = 0; mu = 0; endtask

  task automatic model(input longint vu, vl, ra, rb, rc, lm, input bit md);
    longint err, e, k, ka, s, th;
    err = sat(vl - vu);
    e = err;
    if (!md) begin
      e = sat(rnd(FB * myp + FA * (err + mxp)));
      mxp = err; myp = e;
    end
    k  = md ? KCH : KZS;
    ka = rnd(k * (md ? ACH : AZS));
    s  = mu + rnd(k * e - ka * mep);
    clamped = (s > lm) || (s < -lm);
    if (s > lm) s = lm;
    if (s < -lm) s = -lm;
    mep = e; mu = s;
    th  = sat(rnd(TH * mu));
    ea  = md ? ra : sat(ra + th);
    eb  = md ? rb : sat(rb + th);
    ec  = md ? rc : sat(rc + th);
    ech = md ? mu : 0;
  endtask

  task automatic check_zero(input string req);
    chk(valid == 0, req, valid, 0);
    chk(comp == 0 && chop_ref == 0, req, comp, 0);
    chk(out_a == 0 && out_b == 0 && out_c == 0, req, out_a, 0);
  endtask

  task automatic step(input longint vu, vl, ra, rb, rc, lm);
    string rq, rp;
    @(negedge clk);
    v_up = 16'(vu); v_lo = 16'(vl); ref_a = 16'(ra); ref_b = 16'(rb); ref_c = 16'(rc);
    lim = 15'(lm); strobe = 1;
    model(vu, vl, ra, rb, rc, lm, mode);
    @(negedge clk);
    strobe = 0;
    rq = mode ? "R5" : "R3/R4";
    if (clamped) rq = "R8";
    rp = mode ? "R7" : "R6";
    chk(valid == 1, "R2", valid, 1);
    chk(comp == mu, rq, comp, mu);
    chk(out_a == ea, rp, out_a, ea);
    chk(out_b == eb, rp, out_b, eb);
    chk(out_c == ec, rp, out_c, ec);
    chk(chop_ref == ech, rp, chop_ref, ech);
    for (int g = 0; g < int'($urandom_range(1, 3)); g++) begin
      @(negedge clk);
      chk(valid == 0, "R2", valid, 0);
      chk(comp == mu && out_a == ea, "R2", comp, mu);
    end
  endtask

  task automatic set_mode(input bit m);
    @(negedge clk); mode = m;
    @(negedge clk);
    mclear();
    check_zero("R9");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check_zero("R9");
    rst = 0;

    set_mode(1);
    step(100, 0, 0, 0, 0, 20000);
    chk(comp == -1400, "R1", comp, -1400);
    step(4000, 0, 10, 20, 30, 2000);
    chk(comp == -2000, "R8", comp, -2000);
    step(0, 100, 10, 20, 30, 2000);
    step(0, 100, 10, 20, 30, 2000);

    @(negedge clk); mode = 0; strobe = 1;
    @(negedge clk); strobe = 0;
    mclear();
    check_zero("R9");

    for (int i = 0; i < 20; i++) step(0, 3000, 32700, -32700, 0, 30000);
    chk(out_a == 32767, "R6", out_a, 32767);
    for (int i = 0; i < 5; i++) step(2000, 0, 100, 200, 300, 30000);

    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    mclear();
    check_zero("R9");

    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 15) == 0) set_mode(~mode);
      if ($urandom_range(0, 7) == 0)
        step(longint'($urandom_range(0, 16383)) - 8192, longint'($urandom_range(0, 16383)) - 8192,
             32767 - longint'($urandom_range(0, 50)), -32768 + longint'($urandom_range(0, 50)),
             longint'($urandom_range(0, 65535)) - 32768, longint'($urandom_range(1, 32767)));
      else
        step(longint'($urandom_range(0, 16383)) - 8192, longint'($urandom_range(0, 16383)) - 8192,
             longint'($urandom_range(0, 32767)) - 16384, longint'($urandom_range(0, 32767)) - 16384,
             longint'($urandom_range(0, 32767)) - 16384, longint'($urandom_range(1, 32767)));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule